// File: doc/BRIEF.md
# Edge-Triggered DMA Request Acceptor

This block takes an active-low DMA request line for a single channel and turns each accepted request into one block transfer. Software, or a control block, arms the channel with a one-cycle enable pulse that also loads a block size and a transfer count. From the next clock edge the request line is sampled on every edge. A low level that survives two consecutive samples while acceptance is open becomes a pending request, and that pending request drives a bus request output.

When the grant input is high, the channel activates. The pending request is dropped, acceptance closes, and the channel runs source reads, then destination writes, then one dead cycle. Acceptance opens again only after the request line has been seen high at some point after the activation. It never opens before the dead cycle has finished. A channel stops by itself when its transfer count runs out. An external end pulse also stops it: the stop is immediate when no block is running, and otherwise waits until the running block's dead cycle.

Top module: `dmar_acceptor`

## Requirements
- R1: While rst_ni is low, bus_req_o, rd_o and wr_o are 0 and phase_o is 0 (idle). After reset the channel is disabled, so a low request line raises no bus request until an enable pulse arrives.
- R2: The request line is first sampled on the clock edge after the edge that captured en_set_i. An enable pulse with xfer_cnt_i equal to 0 leaves the channel disabled.
- R3: A pending request is latched when the line is sampled low on two consecutive edges and acceptance is open at the second one. bus_req_o is 1 while the request is pending. A low level that lasts only one sample is not accepted.
- R4: A pending request is held as long as grant_i is low. On the first edge where grant_i is high (and xfer_end_i is low), the channel enters the read phase, bus_req_o drops and acceptance closes.
- R5: phase_o encodes idle=0, read=1, write=2, dead=3. Each block has exactly B read cycles, then B write cycles, then one dead cycle, then returns to idle. B is the loaded block size, and a loaded size of 0 counts as 1. rd_o is 1 exactly in read cycles and wr_o is 1 exactly in write cycles.
- R6: If the line was sampled high on any edge from activation up to and including the edge that ends the dead cycle, acceptance reopens at that edge.
- R7: If no high sample has occurred by the end of the dead cycle, acceptance stays closed in idle until a high sample opens it. A later low held for two samples is then accepted.
- R8: Low samples taken while acceptance is closed or while a block runs create no pending request: bus_req_o stays 0.
- R9: Each finished block consumes one unit of the loaded count. After the block that uses the last unit, the channel is disabled and further requests raise no bus request.
- R10: An xfer_end_i pulse in idle disables the channel at that edge, dropping any pending request, and it takes priority over a grant in the same cycle. During a block it lets the block finish in full and disables the channel at the end of the dead cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_set_i | input | 1 | One-cycle pulse that enables the channel and loads size and count |
| blk_size_i | input | BLK_W | Cycles per read run and per write run |
| xfer_cnt_i | input | CNT_W | Number of blocks before self-disable |
| xfer_end_i | input | 1 | Transfer end / stop pulse |
| dreq_ni | input | 1 | DMA request line, active low |
| grant_i | input | 1 | Bus released to the channel |
| bus_req_o | output | 1 | Pending request, asks for the bus |
| rd_o | output | 1 | Source read strobe |
| wr_o | output | 1 | Destination write strobe |
| phase_o | output | 2 | Channel phase, encoding per R5 |

## Verification
Detecting the line's high level and finishing the dead cycle can happen on the same edge. The bench provokes this by holding the line low through a whole block and raising it only during the dead cycle. It then judges that acceptance reopened at that edge by requiring bus_req_o to be 0 one edge later and 1 two edges later. A second collision is an end pulse arriving on the edge where a pending request meets a grant. The bench requires the phase to stay idle and the bus request to vanish.

// File: rtl/dmar_pkg.sv
package dmar_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2,
    PH_DEAD  = 2'd3
  } phase_e;
endpackage

// File: rtl/dmar_sampler.sv
module dmar_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic act_i,
  input  logic dead_end_i,
  input  logic idle_i,
  input  logic dreq_ni,
  output logic pend_o
);
  logic low_q, pend_q, open_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q  <= 1'b0;
      pend_q <= 1'b0;
      open_q <= 1'b1;
      hi_q   <= 1'b0;
    end else begin
      low_q <= en_i & ~dreq_ni;
      if (!en_i) begin
        pend_q <= 1'b0;
        open_q <= 1'b1;
        hi_q   <= 1'b0;
      end else if (act_i) begin
        pend_q <= 1'b0;
        open_q <= 1'b0;
        hi_q   <= 1'b0;
      end else begin
        // second consecutive low sample while open
        if (open_q && !dreq_ni && low_q) pend_q <= 1'b1;
        if (!open_q) begin
          if (dreq_ni) hi_q <= 1'b1;
          if ((hi_q || dreq_ni) && (dead_end_i || idle_i)) begin
            open_q <= 1'b1;
            hi_q   <= 1'b0;
          end
        end
      end
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/dmar_seq.sv
module dmar_seq
  import dmar_pkg::*;
#(
  parameter int BLK_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_set_i,
  input  logic [BLK_W-1:0] blk_size_i,
  input  logic [CNT_W-1:0] xfer_cnt_i,
  input  logic             xfer_end_i,
  input  logic             pend_i,
  input  logic             grant_i,
  output logic             en_o,
  output logic             act_o,
  output logic             dead_end_o,
  output phase_e           phase_o
);
  localparam logic [BLK_W-1:0] BLK_ONE = BLK_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  phase_e           phase_q;
  logic [BLK_W-1:0] beat_q, blk_q;
  logic [CNT_W-1:0] left_q;
  logic             en_q, stop_q;

  assign act_o      = en_q && pend_i && grant_i && !xfer_end_i && (phase_q == PH_IDLE);
  assign dead_end_o = (phase_q == PH_DEAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      beat_q  <= '0;
      blk_q   <= BLK_ONE;
      left_q  <= '0;
      en_q    <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      if (!en_q && en_set_i && (xfer_cnt_i != '0)) begin
        en_q   <= 1'b1;
        left_q <= xfer_cnt_i;
        blk_q  <= (blk_size_i == '0) ? BLK_ONE : blk_size_i;
        stop_q <= 1'b0;
      end
      unique case (phase_q)
        PH_IDLE: begin
          if (en_q && xfer_end_i) en_q <= 1'b0;
          else if (act_o) begin
            phase_q <= PH_READ;
            beat_q  <= blk_q - BLK_ONE;
          end
        end
        PH_READ: begin
          if (en_q && xfer_end_i) stop_q <= 1'b1;
          if (beat_q == '0) begin
            phase_q <= PH_WRITE;
            beat_q  <= blk_q - BLK_ONE;
          end else beat_q <= beat_q - BLK_ONE;
        end
        PH_WRITE: begin
          if (en_q && xfer_end_i) stop_q <= 1'b1;
          if (beat_q == '0) phase_q <= PH_DEAD;
          else beat_q <= beat_q - BLK_ONE;
        end
        PH_DEAD: begin
          phase_q <= PH_IDLE;
          left_q  <= left_q - CNT_ONE;
          stop_q  <= 1'b0;
          if (left_q == CNT_ONE || stop_q || xfer_end_i) en_q <= 1'b0;
        end
      endcase
    end
  end

  assign en_o    = en_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/dmar_acceptor.sv
module dmar_acceptor
  import dmar_pkg::*;
#(
  parameter int BLK_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_set_i,
  input  logic [BLK_W-1:0] blk_size_i,
  input  logic [CNT_W-1:0] xfer_cnt_i,
  input  logic             xfer_end_i,
  input  logic             dreq_ni,
  input  logic             grant_i,
  output logic             bus_req_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic [1:0]       phase_o
);
  logic   en, act, dead_end, pend;
  phase_e phase;

  dmar_seq #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_set_i   (en_set_i),
    .blk_size_i (blk_size_i),
    .xfer_cnt_i (xfer_cnt_i),
    .xfer_end_i (xfer_end_i),
    .pend_i     (pend),
    .grant_i    (grant_i),
    .en_o       (en),
    .act_o      (act),
    .dead_end_o (dead_end),
    .phase_o    (phase)
  );

  dmar_sampler u_smp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .act_i      (act),
    .dead_end_i (dead_end),
    .idle_i     (phase == PH_IDLE),
    .dreq_ni    (dreq_ni),
    .pend_o     (pend)
  );

  assign bus_req_o = pend & en;
  assign rd_o      = (phase == PH_READ);
  assign wr_o      = (phase == PH_WRITE);
  assign phase_o   = phase;
endmodule

// File: rtl/dmar_acceptor_chk.sv
module dmar_acceptor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       xfer_end_i,
  input logic       grant_i,
  input logic       bus_req_o,
  input logic       rd_o,
  input logic       wr_o,
  input logic [1:0] phase_o
);
  localparam logic [1:0] IDL = 2'd0, RDP = 2'd1, WRP = 2'd2, DDP = 2'd3;

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o)); // R5
  AST_READ_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == RDP) |=> (phase_o == RDP || phase_o == WRP)); // R5
  AST_WRITE_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == WRP) |=> (phase_o == WRP || phase_o == DDP)); // R5
  AST_DEAD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == DDP) |=> (phase_o == IDL)); // R5
  AST_START_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == IDL && !(bus_req_o && grant_i && !xfer_end_i)) |=> (phase_o != RDP)); // R4
  AST_ACT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == IDL && bus_req_o && grant_i && !xfer_end_i) |=> (phase_o == RDP && !bus_req_o)); // R4
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !grant_i && !xfer_end_i) |=> bus_req_o); // R4
  AST_NO_REQ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != IDL) |-> !bus_req_o); // R8
endmodule

bind dmar_acceptor dmar_acceptor_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .xfer_end_i (xfer_end_i),
  .grant_i    (grant_i),
  .bus_req_o  (bus_req_o),
  .rd_o       (rd_o),
  .wr_o       (wr_o),
  .phase_o    (phase_o)
);

// File: tb/dmar_acceptor_tb.sv
module dmar_acceptor_tb;
  localparam int BLK_W = 8;
  localparam int CNT_W = 16;
  localparam logic [1:0] IDL = 2'd0, RDP = 2'd1, WRP = 2'd2, DDP = 2'd3;

  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic             rst_ni = 1'b0;
  logic             en_set_i = 1'b0;
  logic [BLK_W-1:0] blk_size_i = '0;
  logic [CNT_W-1:0] xfer_cnt_i = '0;
  logic             xfer_end_i = 1'b0;
  logic             dreq_ni = 1'b1;
  logic             grant_i = 1'b0;
  logic             bus_req_o, rd_o, wr_o;
  logic [1:0]       phase_o;

  dmar_acceptor #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_dut (.*);

  int n_chk = 0, n_bad = 0, m_chk = 0, m_bad = 0;
  int cur_blk = 1, n_rd = 0, n_wr = 0, n_dead = 0, run = 0;
  logic [1:0] prev_ph = 2'd0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic wait_ph(input logic [1:0] p, input string req);
    int k = 0;
    while (phase_o != p && k < 200) begin tick(); k++; end
    chk(phase_o == p, req, phase_o, p);
  endtask

  task automatic enable(input int blk, input int cnt);
    blk_size_i = BLK_W'(blk);
    xfer_cnt_i = CNT_W'(cnt);
    en_set_i   = 1'b1;
    tick();
    en_set_i   = 1'b0;
  endtask

  // phase sequence monitor: R5 run lengths and strobes
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      prev_ph = IDL; run = 0;
    end else begin
      m_chk++;
      if (rd_o != (phase_o == RDP) || wr_o != (phase_o == WRP)) begin
        m_bad++; $display("FAIL R5 strobe rd=%0d wr=%0d phase=%0d", rd_o, wr_o, phase_o);
      end
      if (phase_o == RDP) n_rd++;
      if (phase_o == WRP) n_wr++;
      if (phase_o == DDP) n_dead++;
      if (phase_o == prev_ph) run++;
      else begin
        if (prev_ph == RDP) begin
          m_chk++;
          if (run != cur_blk || phase_o != WRP) begin
            m_bad++; $display("FAIL R5 read run actual=%0d/%0d expected=%0d/2", run, phase_o, cur_blk);
          end
        end
        if (prev_ph == WRP) begin
          m_chk++;
          if (run != cur_blk || phase_o != DDP) begin
            m_bad++; $display("FAIL R5 write run actual=%0d/%0d expected=%0d/3", run, phase_o, cur_blk);
          end
        end
        if (prev_ph == DDP) begin
          m_chk++;
          if (run != 1 || phase_o != IDL) begin
            m_bad++; $display("FAIL R5 dead run actual=%0d/%0d expected=1/0", run, phase_o);
          end
        end
        run = 1;
      end
      prev_ph = phase_o;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + m_chk, n_bad + m_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state with active-looking inputs
    dreq_ni = 1'b0; grant_i = 1'b1;
    tick(3);
    chk(!bus_req_o && !rd_o && !wr_o && phase_o == IDL, "R1", {bus_req_o, phase_o}, 0);
    rst_ni = 1'b1;
    // R1/R2: disabled after reset, no sampling without enable
    for (int i = 0; i < 6; i++) begin tick(); chk(!bus_req_o && phase_o == IDL, "R2", bus_req_o, 0); end
    enable(3, 0);
    for (int i = 0; i < 4; i++) begin tick(); chk(!bus_req_o, "R2 zero count", bus_req_o, 0); end

    // R2/R3 latency, R4 hold and activation
    grant_i = 1'b0; cur_blk = 1;
    enable(1, 1);
    tick(); chk(!bus_req_o, "R2", bus_req_o, 0);
    tick(); chk(bus_req_o, "R3", bus_req_o, 1);
    for (int i = 0; i < 5; i++) begin tick(); chk(bus_req_o && phase_o == IDL, "R4 hold", bus_req_o, 1); end
    grant_i = 1'b1;
    tick(); chk(phase_o == RDP && !bus_req_o, "R4 activate", phase_o, RDP);
    dreq_ni = 1'b1;
    wait_ph(IDL, "R5");

    // R3: single low sample rejected
    enable(1, 2);
    tick(2);
    dreq_ni = 1'b0; tick(); dreq_ni = 1'b1;
    for (int i = 0; i < 4; i++) begin tick(); chk(!bus_req_o && phase_o == IDL, "R3 short", bus_req_o, 0); end

    // R10: end in idle beats a same-cycle grant
    dreq_ni = 1'b0;
    tick(); tick(); chk(bus_req_o, "R3", bus_req_o, 1);
    grant_i = 1'b1;
    // pend visible now, next edge would activate
    xfer_end_i = 1'b1; tick(); xfer_end_i = 1'b0;
    chk(phase_o == IDL && !bus_req_o, "R10 idle", phase_o, IDL);
    dreq_ni = 1'b1; tick(); dreq_ni = 1'b0;
    for (int i = 0; i < 5; i++) begin tick(); chk(!bus_req_o && phase_o == IDL, "R10 disabled", bus_req_o, 0); end
    dreq_ni = 1'b1;

    // R10: end during a block, block completes then disabled
    cur_blk = 3; n_wr = 0;
    dreq_ni = 1'b0; enable(3, 5);
    wait_ph(RDP, "R4");
    xfer_end_i = 1'b1; tick(); xfer_end_i = 1'b0;
    dreq_ni = 1'b1;
    wait_ph(IDL, "R10");
    chk(n_wr == 3, "R10 full block", n_wr, 3);
    dreq_ni = 1'b0;
    for (int i = 0; i < 6; i++) begin tick(); chk(!bus_req_o, "R10 after block", bus_req_o, 0); end
    dreq_ni = 1'b1;

    // R6/R7/R8: re-arm orderings, blk 2 cnt 4
    cur_blk = 2;
    dreq_ni = 1'b0; enable(2, 4);
    wait_ph(RDP, "R4");
    wait_ph(IDL, "R5");
    for (int i = 0; i < 10; i++) begin tick(); chk(!bus_req_o && phase_o == IDL, "R7 closed", bus_req_o, 0); end
    dreq_ni = 1'b1; tick(); dreq_ni = 1'b0;
    tick(); chk(!bus_req_o, "R7 first low", bus_req_o, 0);
    tick(); chk(bus_req_o, "R7 accept", bus_req_o, 1);
    // block 2: high only in dead cycle
    wait_ph(RDP, "R4");
    wait_ph(DDP, "R5");
    dreq_ni = 1'b1; tick();
    chk(phase_o == IDL && !bus_req_o, "R6 dead edge", bus_req_o, 0);
    dreq_ni = 1'b0;
    tick(); chk(!bus_req_o, "R6 first low", bus_req_o, 0);
    tick(); chk(bus_req_o, "R6 coincide accept", bus_req_o, 1);
    // block 3: high mid-block then low, lows ignored while busy
    wait_ph(RDP, "R4");
    dreq_ni = 1'b1; tick(); dreq_ni = 1'b0;
    for (int k = 0; k < 20 && phase_o != IDL; k++) begin
      chk(!bus_req_o, "R8 busy", bus_req_o, 0); tick();
    end
    chk(phase_o == IDL && !bus_req_o, "R6 reopen edge", bus_req_o, 0);
    tick(); chk(bus_req_o, "R6 reopen accept", bus_req_o, 1);
    // block 4 is last
    wait_ph(RDP, "R4");
    dreq_ni = 1'b1;
    wait_ph(IDL, "R5");
    dreq_ni = 1'b0;
    for (int i = 0; i < 8; i++) begin tick(); chk(!bus_req_o && phase_o == IDL, "R9 exhausted", bus_req_o, 0); end
    dreq_ni = 1'b1; tick(); dreq_ni = 1'b0;
    for (int i = 0; i < 4; i++) begin tick(); chk(!bus_req_o, "R9 exhausted", bus_req_o, 0); end
    dreq_ni = 1'b1;

    // sweep block size and count
    for (int blk = 1; blk <= 4; blk++) begin
      for (int cnt = 1; cnt <= 3; cnt++) begin
        cur_blk = blk; grant_i = 1'b1; dreq_ni = 1'b1;
        tick();
        n_rd = 0; n_wr = 0; n_dead = 0;
        enable(blk, cnt);
        for (int k = 0; k < cnt; k++) begin
          dreq_ni = 1'b0;
          wait_ph(RDP, "R3");
          dreq_ni = 1'b1;
          wait_ph(IDL, "R5");
        end
        dreq_ni = 1'b0;
        for (int i = 0; i < 4; i++) begin tick(); chk(!bus_req_o && phase_o == IDL, "R9", bus_req_o, 0); end
        dreq_ni = 1'b1;
        chk(n_rd == blk * cnt, "R5 reads", n_rd, blk * cnt);
        chk(n_wr == blk * cnt, "R5 writes", n_wr, blk * cnt);
        chk(n_dead == cnt, "R9 blocks", n_dead, cnt);
      end
    end

    // R1: asynchronous reset drops a pending request
    dreq_ni = 1'b0; grant_i = 1'b0;
    enable(1, 2);
    tick(2); chk(bus_req_o, "R3", bus_req_o, 1);
    rst_ni = 1'b0; #1;
    chk(!bus_req_o && phase_o == IDL, "R1 async", bus_req_o, 0);
    tick(); rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) begin tick(); chk(!bus_req_o, "R1 disabled", bus_req_o, 0); end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule